// File: doc/BRIEF.md
# Alternating sync-word frame sequencer

This block supplies the 8-bit word carried in synchronization channel 0 of every frame in a 16-frame multiframe. A frame counter steps from 1 to 16 on each frame strobe and then starts again at 1. Frames with an odd number carry a fixed alignment pattern. Frames with an even number carry a service word that holds two alarm bits and four spare bits. In both formats the most significant bit is a check bit. A separate CRC unit computes it, and this block only passes it through.

A small state machine follows the frame parity. It has two named states. `ST_ALIGN` is active in odd frames and `ST_SERVICE` in even frames. Transition `T_TO_SERVICE` goes from `ST_ALIGN` to `ST_SERVICE` on a frame strobe. Transition `T_TO_ALIGN` goes from `ST_SERVICE` to `ST_ALIGN` on a frame strobe. Without a strobe the state stays where it is. Reset places the machine in `ST_ALIGN` at frame 1.

On each strobe the check bit, the alarm flags and the spare bits are captured. The word therefore stays unchanged for the whole frame, whatever those inputs do between strobes. Serializing the word onto a line is handled elsewhere.

Top module: `sync_word_seq`

## Requirements
- R1: After reset, frame_num is 1, even_frame is 0 and sync_word is 8'h1B (the captured check bit, alarm flags and spare bits are all 0).
- R2: Each cycle with frame_stb high increases frame_num by one. frame_num stays within 1 to 16.
- R3: A strobe taken while frame_num is 16 sets frame_num to 1.
- R4: In odd frames, sync_word[6:0] is 7'b0011011, with bit 6 = 0.
- R5: In even frames, sync_word[6] is 1, sync_word[5] is alarm_a, sync_word[4] is alarm_b and sync_word[3:0] is spare_bits. All of these are the values captured at the strobe that started the frame.
- R6: In every frame, sync_word[7] equals chk_bit as captured at the strobe that started the frame.
- R7: While frame_stb is low, sync_word and frame_num do not change, even when chk_bit, alarm_a, alarm_b or spare_bits change.
- R8: even_frame is 1 exactly when frame_num is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse that starts the next frame |
| chk_bit | input | 1 | Check bit from the CRC unit |
| alarm_a | input | 1 | First alarm flag (word bit 5) |
| alarm_b | input | 1 | Second alarm flag (word bit 4) |
| spare_bits | input | 4 | Spare service bits (word bits 3:0) |
| sync_word | output | 8 | Channel-0 word for the current frame |
| frame_num | output | 5 | Current frame number, 1 to 16 |
| even_frame | output | 1 | High in even-numbered frames |

## Verification
A table of twenty stimulus vectors runs the counter through a full multiframe and across the wrap point. The vectors mix check-bit values, alarm pairs and spare patterns such as all ones, all zeros and alternating bits. This separates three things: fields that are captured correctly, fields that are swapped, and fields that leak into odd frames. Between strobes every input is driven to its complement. This shows that the word is held and not merely passed straight through. A reset in the middle of a multiframe shows that the counter and the captured check bit both go back to their initial values.

// File: rtl/sync_word_seq_pkg.sv
package sync_word_seq_pkg;
    localparam int FRAMES_DEF  = 16;
    localparam int SPARE_W_DEF = 4;

    typedef enum logic [0:0] {
        ST_ALIGN   = 1'b0,
        ST_SERVICE = 1'b1
    } frame_state_t;
endpackage

// File: rtl/sync_frame_ctr.sv
module sync_frame_ctr #(
    parameter int FRAMES = 16,
    localparam int FN_W = $clog2(FRAMES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    output logic [FN_W-1:0] count
);
    localparam logic [FN_W-1:0] LAST  = FN_W'(FRAMES);
    localparam logic [FN_W-1:0] FIRST = FN_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= FIRST;
        end else if (adv) begin
            if (count == LAST) begin
                count <= FIRST;
            end else begin
                count <= count + FIRST;
            end
        end
    end
endmodule

// File: rtl/sync_field_cap.sv
module sync_field_cap #(
    parameter int SPARE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               chk_in,
    input  logic               a_in,
    input  logic               b_in,
    input  logic [SPARE_W-1:0] spare_in,
    output logic               chk_q,
    output logic               a_q,
    output logic               b_q,
    output logic [SPARE_W-1:0] spare_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_q   <= 1'b0;
            a_q     <= 1'b0;
            b_q     <= 1'b0;
            spare_q <= '0;
        end else if (load) begin
            chk_q   <= chk_in;
            a_q     <= a_in;
            b_q     <= b_in;
            spare_q <= spare_in;
        end
    end
endmodule

// File: rtl/sync_word_fmt.sv
module sync_word_fmt
    import sync_word_seq_pkg::*;
#(
    parameter int SPARE_W = 4,
    localparam int WORD_W = SPARE_W + 4,
    localparam int TAIL_W = WORD_W - 1
) (
    input  frame_state_t       state,
    input  logic               chk_q,
    input  logic               a_q,
    input  logic               b_q,
    input  logic [SPARE_W-1:0] spare_q,
    output logic [WORD_W-1:0]  word
);
    // Alignment tail below the check bit: 0 0 1 1 0 1 1 for the default width.
    localparam logic [TAIL_W-1:0] ALIGN_TAIL = TAIL_W'(7'b0011011);

    logic [TAIL_W-1:0] svc_tail;
    assign svc_tail = {1'b1, a_q, b_q, spare_q};

    genvar gi;
    generate
        for (gi = 0; gi < TAIL_W; gi++) begin : g_tail
            always_comb begin
                unique case (state)
                    ST_ALIGN:   word[gi] = ALIGN_TAIL[gi];
                    ST_SERVICE: word[gi] = svc_tail[gi];
                    default:    word[gi] = ALIGN_TAIL[gi];
                endcase
            end
        end
    endgenerate

    assign word[WORD_W-1] = chk_q;
endmodule

// File: rtl/sync_word_seq.sv
module sync_word_seq
    import sync_word_seq_pkg::*;
#(
    parameter int FRAMES  = FRAMES_DEF,
    parameter int SPARE_W = SPARE_W_DEF,
    localparam int FN_W   = $clog2(FRAMES + 1),
    localparam int WORD_W = SPARE_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_stb,
    input  logic               chk_bit,
    input  logic               alarm_a,
    input  logic               alarm_b,
    input  logic [SPARE_W-1:0] spare_bits,
    output logic [WORD_W-1:0]  sync_word,
    output logic [FN_W-1:0]    frame_num,
    output logic               even_frame
);
    frame_state_t state_q, state_d;

    logic               chk_q, a_q, b_q;
    logic [SPARE_W-1:0] spare_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ALIGN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions T_TO_SERVICE and T_TO_ALIGN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ALIGN:   if (frame_stb) state_d = ST_SERVICE;
            ST_SERVICE: if (frame_stb) state_d = ST_ALIGN;
            default:    state_d = ST_ALIGN;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_ALIGN:   even_frame = 1'b0;
            ST_SERVICE: even_frame = 1'b1;
            default:    even_frame = 1'b0;
        endcase
    end

    sync_frame_ctr #(.FRAMES(FRAMES)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (frame_stb),
        .count (frame_num)
    );

    sync_field_cap #(.SPARE_W(SPARE_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frame_stb),
        .chk_in   (chk_bit),
        .a_in     (alarm_a),
        .b_in     (alarm_b),
        .spare_in (spare_bits),
        .chk_q    (chk_q),
        .a_q      (a_q),
        .b_q      (b_q),
        .spare_q  (spare_q)
    );

    sync_word_fmt #(.SPARE_W(SPARE_W)) u_fmt (
        .state   (state_q),
        .chk_q   (chk_q),
        .a_q     (a_q),
        .b_q     (b_q),
        .spare_q (spare_q),
        .word    (sync_word)
    );
endmodule

// File: rtl/sync_word_seq_chk.sv
module sync_word_seq_chk #(
    parameter int FRAMES  = 16,
    parameter int SPARE_W = 4,
    localparam int FN_W   = $clog2(FRAMES + 1),
    localparam int WORD_W = SPARE_W + 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_stb,
    input logic               chk_bit,
    input logic               alarm_a,
    input logic               alarm_b,
    input logic [SPARE_W-1:0] spare_bits,
    input logic [WORD_W-1:0]  sync_word,
    input logic [FN_W-1:0]    frame_num,
    input logic               even_frame
);
    localparam logic [FN_W-1:0] LAST = FN_W'(FRAMES);
    localparam logic [FN_W-1:0] ONE  = FN_W'(1);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && frame_num != LAST) |=> (frame_num == $past(frame_num) + ONE));

    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_num >= ONE && frame_num <= LAST));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && frame_num == LAST) |=> (frame_num == ONE));

    p_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_num[0] || (sync_word[WORD_W-2:0] == (WORD_W-1)'(7'b0011011)));

    p_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && frame_num[0]) |=>
        (sync_word[WORD_W-2:0] == {1'b1, $past(alarm_a), $past(alarm_b), $past(spare_bits)}));

    p_check_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> (sync_word[WORD_W-1] == $past(chk_bit)));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_stb |=> ($stable(sync_word) && $stable(frame_num)));

    p_parity_r8: assert property (@(posedge clk) disable iff (!rst_n)
        even_frame == !frame_num[0]);
endmodule

bind sync_word_seq sync_word_seq_chk #(.FRAMES(FRAMES), .SPARE_W(SPARE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_stb  (frame_stb),
    .chk_bit    (chk_bit),
    .alarm_a    (alarm_a),
    .alarm_b    (alarm_b),
    .spare_bits (spare_bits),
    .sync_word  (sync_word),
    .frame_num  (frame_num),
    .even_frame (even_frame)
);

// File: tb/sim_sync_word_seq.sv
`timescale 1ns/1ps
module sim_sync_word_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 1'b0;
    logic       chk_bit = 1'b0;
    logic       alarm_a = 1'b0;
    logic       alarm_b = 1'b0;
    logic [3:0] spare_bits = 4'h0;
    logic [7:0] sync_word;
    logic [4:0] frame_num;
    logic       even_frame;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_frame = 1;
    logic [7:0] exp_word;

    always #4 clk = ~clk;

    sync_word_seq u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_stb  (frame_stb),
        .chk_bit    (chk_bit),
        .alarm_a    (alarm_a),
        .alarm_b    (alarm_b),
        .spare_bits (spare_bits),
        .sync_word  (sync_word),
        .frame_num  (frame_num),
        .even_frame (even_frame)
    );

    // Stimulus vectors: {chk_bit, alarm_a, alarm_b, spare_bits}
    localparam logic [6:0] VEC [0:19] = '{
        7'b1_10_1010, 7'b0_01_0101, 7'b1_11_1111, 7'b0_00_0000,
        7'b1_00_1001, 7'b1_10_0110, 7'b0_11_1000, 7'b0_01_0001,
        7'b1_01_1100, 7'b0_10_0011, 7'b1_11_0000, 7'b0_00_1111,
        7'b1_10_0101, 7'b0_01_1010, 7'b1_00_0111, 7'b1_11_1110,
        7'b0_10_0010, 7'b1_01_1011, 7'b0_11_0100, 7'b1_00_1101
    };

    task automatic check(input string req, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] model_word(input int fr, input logic [6:0] v);
        if (fr % 2 == 1) return {v[6], 7'b0011011};
        return {v[6], 1'b1, v[5], v[4], v[3:0]};
    endfunction

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 frame", int'(frame_num), 1);
        check("R1 parity", int'(even_frame), 0);
        check("R1 word", int'(sync_word), 8'h1B);

        for (int i = 0; i < 20; i++) begin
            {chk_bit, alarm_a, alarm_b, spare_bits} = VEC[i];
            frame_stb = 1'b1;
            @(negedge clk);
            frame_stb = 1'b0;
            exp_frame = (exp_frame == 16) ? 1 : exp_frame + 1;
            exp_word  = model_word(exp_frame, VEC[i]);
            check((exp_frame == 1) ? "R3 wrap" : "R2 step", int'(frame_num), exp_frame);
            check("R8 parity", int'(even_frame), (exp_frame % 2 == 0) ? 1 : 0);
            check((exp_frame % 2 == 1) ? "R4 R6 odd word" : "R5 R6 even word",
                  int'(sync_word), int'(exp_word));
            {chk_bit, alarm_a, alarm_b, spare_bits} = ~VEC[i];
            repeat (3) @(negedge clk);
            check("R7 word held", int'(sync_word), int'(exp_word));
            check("R7 frame held", int'(frame_num), exp_frame);
        end

        // Mid-multiframe reset
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 frame after reset", int'(frame_num), 1);
        check("R1 word after reset", int'(sync_word), 8'h1B);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule